// File: doc/BRIEF.md
# Cross-Domain Mailbox Pair

This block gives two independently clocked ports a pair of 36-bit message registers that bypass the main data queue. Port A posts messages into the first mailbox, and port B collects them. Port B posts into the second mailbox, and port A collects them. Each mailbox has an active-low occupancy flag. A post drives the flag low in the poster's clock domain. A collection releases it in the collector's domain. Each side also has its own view of every flag, and the two views are kept consistent through toggle synchronizers.

Each port has a chip select (active low), an enable, a direction input and a mailbox select. When the mailbox select is low, an access is routed to a FIFO strobe for the neighbouring queue logic. The pad drivers are outside this block. Each port instead provides a registered output-enable and a registered data word.

Top module: `xdom_mailbox`

## Requirements
- R1: A port-A mailbox write (a_cs_n=0, a_en=1, a_wr=1, a_mbox=1) while a_mb1_full_n is high stores a_din into mailbox 1 and drives a_mb1_full_n low on that same clk_a edge.
- R2: A port-B mailbox read (b_cs_n=0, b_en=1, b_rd=1, b_mbox=1) while b_mb1_full_n is low drives b_mb1_full_n high on that clk_b edge. a_mb1_full_n returns high within 4 clk_a edges after that.
- R3: The reverse direction is symmetric. A port-B mailbox write (b_rd=0, b_mbox=1) drives b_mb2_full_n low on that clk_b edge. A port-A mailbox read (a_wr=0, a_mbox=1) while a_mb2_full_n is low drives a_mb2_full_n high on that clk_a edge, and b_mb2_full_n follows within 4 clk_b edges.
- R4: A mailbox write becomes visible as a low flag in the reader domain (b_mb1_full_n or a_mb2_full_n) within 4 edges of the reader clock.
- R5: A mailbox write made while the writer-side flag is low is ignored. The stored word and the flags do not change.
- R6: A mailbox read made while the reader-side flag is high changes no flag in either domain.
- R7: An access needs the chip select low and the enable high. A write is a_wr=1 on port A and b_rd=0 on port B. Any other combination changes no flag.
- R8: a_oe is 1 on the clk_a edge after a_cs_n=0 and a_wr=0, and is 0 otherwise. b_oe is 1 on the clk_b edge after b_cs_n=0 and b_rd=1, and is 0 otherwise.
- R9: On every clk_b edge, b_dout takes mailbox 1 if b_mbox=1 and b_fifo_q if b_mbox=0. On every clk_a edge, a_dout takes mailbox 2 if a_mbox=1 and zero if a_mbox=0.
- R10: a_fifo_wr is high combinationally during a port-A write access with a_mbox=0. b_fifo_rd is high during a port-B read access with b_mbox=0.
- R11: A reset holds every flag high and clears the mailbox words, the output-enables and the data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_mbox | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A write data |
| a_dout | output | 36 | Port A registered read data |
| a_oe | output | 1 | Port A registered output enable |
| a_fifo_wr | output | 1 | Port A FIFO write strobe |
| a_mb1_full_n | output | 1 | Mailbox 1 flag, writer view (clk_a) |
| a_mb2_full_n | output | 1 | Mailbox 2 flag, reader view (clk_a) |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_en | input | 1 | Port B access enable |
| b_rd | input | 1 | Port B direction, 1 = read, 0 = write |
| b_mbox | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write data |
| b_fifo_q | input | 36 | FIFO output word to be muxed onto port B |
| b_dout | output | 36 | Port B registered read data |
| b_oe | output | 1 | Port B registered output enable |
| b_fifo_rd | output | 1 | Port B FIFO read strobe |
| b_mb1_full_n | output | 1 | Mailbox 1 flag, reader view (clk_b) |
| b_mb2_full_n | output | 1 | Mailbox 2 flag, writer view (clk_b) |

## Verification
The properties assume that rst_a and rst_b are asserted together and overlap by several edges of both clocks, so the toggle registers of both domains start out equal. They also assume that a reader collects a mailbox only after its own view has gone low, so the stored word is stable while the other clock samples it. The stimulus keeps to these assumptions. It raises both resets at once for several cycles, and it waits six reader-clock edges after every post before it reads. It changes each port's inputs only on that port's falling clock edge, with two clocks whose periods are unrelated (8 ns and 11 ns).

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_DW_DEF   = 36;
  localparam int unsigned MBX_SYNC_DEF = 2;

  typedef struct packed {
    logic mb_wr;
    logic mb_rd;
    logic fifo_go;
    logic oe;
  } port_ctl_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= 1'b0;
        else if (s == 0) chain_q[s] <= din;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter logic WR_LEVEL   = 1'b1,
  parameter logic FIFO_IS_WR = 1'b1
) (
  input  logic      cs_n,
  input  logic      en,
  input  logic      dir,
  input  logic      mbox,
  output port_ctl_t ctl
);
  logic acc, is_wr;

  always_comb begin
    acc         = ~cs_n & en;
    is_wr       = (dir == WR_LEVEL);
    ctl.mb_wr   = acc & is_wr & mbox;
    ctl.mb_rd   = acc & ~is_wr & mbox;
    ctl.fifo_go = acc & ~mbox & (is_wr == FIFO_IS_WR);
    ctl.oe      = ~cs_n & ~is_wr;
  end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int unsigned DW     = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wr_req,
  input  logic [DW-1:0] wdata,
  output logic          full_wn,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          rd_req,
  output logic [DW-1:0] rdata,
  output logic          full_rn
);
  logic          wr_tgl, rd_tgl;
  logic          rd_tgl_w, wr_tgl_r;
  logic          wr_take, rd_take;
  logic          wr_tgl_nx, rd_tgl_nx;
  logic [DW-1:0] mail_q;

  // writer domain: post only into an empty slot
  assign wr_take   = wr_req & full_wn;
  assign wr_tgl_nx = wr_tgl ^ wr_take;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wr_tgl  <= 1'b0;
      mail_q  <= '0;
      full_wn <= 1'b1;
    end else begin
      wr_tgl  <= wr_tgl_nx;
      if (wr_take) mail_q <= wdata;
      full_wn <= (wr_tgl_nx == rd_tgl_w);
    end
  end

  mbx_sync #(.STAGES(STAGES)) u_rd2w (
    .clk(wclk), .rst(wrst), .din(rd_tgl), .dout(rd_tgl_w)
  );

  // reader domain: collect only an occupied slot
  assign rd_take   = rd_req & ~full_rn;
  assign rd_tgl_nx = rd_tgl ^ rd_take;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rd_tgl  <= 1'b0;
      full_rn <= 1'b1;
    end else begin
      rd_tgl  <= rd_tgl_nx;
      full_rn <= (wr_tgl_r == rd_tgl_nx);
    end
  end

  mbx_sync #(.STAGES(STAGES)) u_w2rd (
    .clk(rclk), .rst(rrst), .din(wr_tgl), .dout(wr_tgl_r)
  );

  assign rdata = mail_q;
endmodule

// File: rtl/xdom_mailbox.sv
module xdom_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DW          = MBX_DW_DEF,
  parameter int unsigned SYNC_STAGES = MBX_SYNC_DEF
) (
  input  logic          clk_a,
  input  logic          rst_a,
  input  logic          a_cs_n,
  input  logic          a_en,
  input  logic          a_wr,
  input  logic          a_mbox,
  input  logic [DW-1:0] a_din,
  output logic [DW-1:0] a_dout,
  output logic          a_oe,
  output logic          a_fifo_wr,
  output logic          a_mb1_full_n,
  output logic          a_mb2_full_n,
  input  logic          clk_b,
  input  logic          rst_b,
  input  logic          b_cs_n,
  input  logic          b_en,
  input  logic          b_rd,
  input  logic          b_mbox,
  input  logic [DW-1:0] b_din,
  input  logic [DW-1:0] b_fifo_q,
  output logic [DW-1:0] b_dout,
  output logic          b_oe,
  output logic          b_fifo_rd,
  output logic          b_mb1_full_n,
  output logic          b_mb2_full_n
);
  port_ctl_t     a_ctl, b_ctl;
  logic [DW-1:0] mail1_q, mail2_q;

  mbx_port_dec #(.WR_LEVEL(1'b1), .FIFO_IS_WR(1'b1)) u_dec_a (
    .cs_n(a_cs_n), .en(a_en), .dir(a_wr), .mbox(a_mbox), .ctl(a_ctl)
  );

  mbx_port_dec #(.WR_LEVEL(1'b0), .FIFO_IS_WR(1'b0)) u_dec_b (
    .cs_n(b_cs_n), .en(b_en), .dir(b_rd), .mbox(b_mbox), .ctl(b_ctl)
  );

  mbx_slot #(.DW(DW), .STAGES(SYNC_STAGES)) u_slot1 (
    .wclk(clk_a), .wrst(rst_a), .wr_req(a_ctl.mb_wr), .wdata(a_din),
    .full_wn(a_mb1_full_n),
    .rclk(clk_b), .rrst(rst_b), .rd_req(b_ctl.mb_rd), .rdata(mail1_q),
    .full_rn(b_mb1_full_n)
  );

  mbx_slot #(.DW(DW), .STAGES(SYNC_STAGES)) u_slot2 (
    .wclk(clk_b), .wrst(rst_b), .wr_req(b_ctl.mb_wr), .wdata(b_din),
    .full_wn(b_mb2_full_n),
    .rclk(clk_a), .rrst(rst_a), .rd_req(a_ctl.mb_rd), .rdata(mail2_q),
    .full_rn(a_mb2_full_n)
  );

  assign a_fifo_wr = a_ctl.fifo_go;
  assign b_fifo_rd = b_ctl.fifo_go;

  always_ff @(posedge clk_a) begin
    if (rst_a) begin
      a_oe   <= 1'b0;
      a_dout <= '0;
    end else begin
      a_oe   <= a_ctl.oe;
      a_dout <= a_mbox ? mail2_q : '0;
    end
  end

  always_ff @(posedge clk_b) begin
    if (rst_b) begin
      b_oe   <= 1'b0;
      b_dout <= '0;
    end else begin
      b_oe   <= b_ctl.oe;
      b_dout <= b_mbox ? mail1_q : b_fifo_q;
    end
  end
endmodule

// File: rtl/xdom_mailbox_chk.sv
module xdom_mailbox_chk #(
  parameter int unsigned DW = 36
) (
  input logic          clk_a,
  input logic          rst_a,
  input logic          clk_b,
  input logic          rst_b,
  input logic          a_cs_n,
  input logic          a_wr,
  input logic          b_cs_n,
  input logic          b_rd,
  input logic          a_oe,
  input logic          b_oe,
  input logic          a_mb_wr,
  input logic          a_mb_rd,
  input logic          b_mb_wr,
  input logic          b_mb_rd,
  input logic          a_mb1_full_n,
  input logic          a_mb2_full_n,
  input logic          b_mb1_full_n,
  input logic          b_mb2_full_n,
  input logic [DW-1:0] mail1_q,
  input logic [DW-1:0] mail2_q
);
  AST_MB1_POST_SETS: assert property (@(posedge clk_a) disable iff (rst_a) (a_mb_wr && a_mb1_full_n) |=> !a_mb1_full_n); // R1
  AST_MB1_TAKE_CLEARS: assert property (@(posedge clk_b) disable iff (rst_b) (b_mb_rd && !b_mb1_full_n) |=> b_mb1_full_n); // R2
  AST_MB2_POST_SETS: assert property (@(posedge clk_b) disable iff (rst_b) (b_mb_wr && b_mb2_full_n) |=> !b_mb2_full_n); // R3
  AST_MB2_TAKE_CLEARS: assert property (@(posedge clk_a) disable iff (rst_a) (a_mb_rd && !a_mb2_full_n) |=> a_mb2_full_n); // R3
  AST_MB1_NO_OVERWRITE: assert property (@(posedge clk_a) disable iff (rst_a) !a_mb1_full_n |=> $stable(mail1_q)); // R5
  AST_MB2_NO_OVERWRITE: assert property (@(posedge clk_b) disable iff (rst_b) !b_mb2_full_n |=> $stable(mail2_q)); // R5
  AST_A_OE_OFF: assert property (@(posedge clk_a) disable iff (rst_a) (a_cs_n || a_wr) |=> !a_oe); // R8
  AST_B_OE_OFF: assert property (@(posedge clk_b) disable iff (rst_b) (b_cs_n || !b_rd) |=> !b_oe); // R8
  AST_A_RESET_FLAGS: assert property (@(posedge clk_a) rst_a |=> (a_mb1_full_n && a_mb2_full_n && !a_oe)); // R11
  AST_B_RESET_FLAGS: assert property (@(posedge clk_b) rst_b |=> (b_mb1_full_n && b_mb2_full_n && !b_oe)); // R11
endmodule

bind xdom_mailbox xdom_mailbox_chk #(.DW(DW)) u_chk (
  .clk_a(clk_a), .rst_a(rst_a), .clk_b(clk_b), .rst_b(rst_b),
  .a_cs_n(a_cs_n), .a_wr(a_wr), .b_cs_n(b_cs_n), .b_rd(b_rd),
  .a_oe(a_oe), .b_oe(b_oe),
  .a_mb_wr(a_ctl.mb_wr), .a_mb_rd(a_ctl.mb_rd),
  .b_mb_wr(b_ctl.mb_wr), .b_mb_rd(b_ctl.mb_rd),
  .a_mb1_full_n(a_mb1_full_n), .a_mb2_full_n(a_mb2_full_n),
  .b_mb1_full_n(b_mb1_full_n), .b_mb2_full_n(b_mb2_full_n),
  .mail1_q(mail1_q), .mail2_q(mail2_q)
);

// File: tb/xdom_mailbox_tb_top.sv
`timescale 1ns/1ps
module xdom_mailbox_tb_top;
  localparam int DW = 36;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a = 1'b1, rst_b = 1'b1;
  logic a_cs_n = 1'b1, a_en = 1'b0, a_wr = 1'b0, a_mbox = 1'b0;
  logic b_cs_n = 1'b1, b_en = 1'b0, b_rd = 1'b0, b_mbox = 1'b0;
  logic [DW-1:0] a_din = '0, b_din = '0, b_fifo_q = '0;
  logic [DW-1:0] a_dout, b_dout;
  logic a_oe, b_oe, a_fifo_wr, b_fifo_rd;
  logic a_mb1_full_n, a_mb2_full_n, b_mb1_full_n, b_mb2_full_n;

  int  ncmp = 0, nmis = 0;
  bit  done = 1'b0;

  always #4.0 clk_a = ~clk_a;
  always #5.5 clk_b = ~clk_b;

  xdom_mailbox #(.DW(DW)) dut_i (.*);

  // {b_cs_n, b_rd, b_mbox, exp_oe, exp_mail1}
  localparam logic [4:0] VEC [8] = '{
    5'b01111, 5'b01010, 5'b11101, 5'b00101,
    5'b10000, 5'b00000, 5'b11000, 5'b01111
  };

  localparam logic [DW-1:0] D1 = 36'h1_2345_6789;
  localparam logic [DW-1:0] D2 = 36'hA_BCDE_F012;
  localparam logic [DW-1:0] D3 = 36'h5_A5A5_A5A5;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    ncmp++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_op(input logic cs_n, input logic en, input logic wr, input logic mb, input logic [DW-1:0] d);
    @(negedge clk_a);
    a_cs_n = cs_n; a_en = en; a_wr = wr; a_mbox = mb; a_din = d;
    @(negedge clk_a);
    a_cs_n = 1'b1; a_en = 1'b0;
  endtask

  task automatic b_op(input logic cs_n, input logic en, input logic rd, input logic mb, input logic [DW-1:0] d);
    @(negedge clk_b);
    b_cs_n = cs_n; b_en = en; b_rd = rd; b_mbox = mb; b_din = d;
    @(negedge clk_b);
    b_cs_n = 1'b1; b_en = 1'b0;
  endtask

  task automatic wait_a(input int n);
    repeat (n) @(negedge clk_a);
  endtask

  task automatic wait_b(input int n);
    repeat (n) @(negedge clk_b);
  endtask

  initial begin
    wait_b(5);
    rst_a = 1'b0; rst_b = 1'b0;
    wait_b(1);
    // R11: reset state
    chk("R11 a_mb1_full_n", a_mb1_full_n, 1);
    chk("R11 a_mb2_full_n", a_mb2_full_n, 1);
    chk("R11 b_mb1_full_n", b_mb1_full_n, 1);
    chk("R11 b_mb2_full_n", b_mb2_full_n, 1);
    chk("R11 a_oe", a_oe, 0);
    chk("R11 b_oe", b_oe, 0);

    // R1: post into mailbox 1
    a_op(0, 1, 1, 1, D1);
    chk("R1 a_mb1_full_n low at write edge", a_mb1_full_n, 0);
    // R4: visible in reader domain
    wait_b(4);
    chk("R4 b_mb1_full_n low", b_mb1_full_n, 0);

    // R8/R9 table on port B (enable low, no access)
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_b);
      b_en = 1'b0; b_cs_n = VEC[i][4]; b_rd = VEC[i][3]; b_mbox = VEC[i][2];
      b_fifo_q = 36'h0_0000_0F00 + DW'(i);
      @(negedge clk_b);
      chk($sformatf("R8 b_oe row %0d", i), b_oe, VEC[i][1]);
      chk($sformatf("R9 b_dout row %0d", i), b_dout, VEC[i][0] ? D1 : 36'h0_0000_0F00 + DW'(i));
    end
    b_cs_n = 1'b1; b_mbox = 1'b0;
    chk("R4 b_mb1_full_n still low after table", b_mb1_full_n, 0);

    // R5: write while full ignored
    a_op(0, 1, 1, 1, D2);
    chk("R5 a_mb1_full_n stays low", a_mb1_full_n, 0);
    wait_b(2);

    // R2: collect mailbox 1
    b_op(0, 1, 1, 1, '0);
    chk("R2 b_mb1_full_n high at read edge", b_mb1_full_n, 1);
    chk("R5 b_dout holds first word", b_dout, D1);
    wait_a(4);
    chk("R2 a_mb1_full_n released", a_mb1_full_n, 1);

    // R3: mailbox 2
    b_op(0, 1, 0, 1, D3);
    chk("R3 b_mb2_full_n low at write edge", b_mb2_full_n, 0);
    wait_a(4);
    chk("R4 a_mb2_full_n low", a_mb2_full_n, 0);
    a_op(0, 1, 0, 1, '0);
    chk("R3 a_mb2_full_n high at read edge", a_mb2_full_n, 1);
    chk("R9 a_dout mailbox 2", a_dout, D3);
    chk("R8 a_oe on read", a_oe, 1);
    wait_b(4);
    chk("R3 b_mb2_full_n released", b_mb2_full_n, 1);

    // R9: port A with mailbox select low gives zero
    a_op(0, 0, 0, 0, '0);
    chk("R9 a_dout zero when mbox low", a_dout, 0);

    // R6: read while empty
    b_op(0, 1, 1, 1, '0);
    chk("R6 b_mb1_full_n stays high", b_mb1_full_n, 1);
    wait_a(6);
    chk("R6 a_mb1_full_n stays high", a_mb1_full_n, 1);
    a_op(0, 1, 1, 1, D2);
    chk("R6 a_mb1_full_n low on next post", a_mb1_full_n, 0);
    wait_b(6);
    chk("R6 b_mb1_full_n low on next post", b_mb1_full_n, 0);
    b_op(0, 1, 1, 1, '0);
    chk("R6 b_dout second word", b_dout, D2);
    wait_a(6);

    // R7: gating
    a_op(1, 1, 1, 1, D3);
    chk("R7 cs_n high blocks write", a_mb1_full_n, 1);
    a_op(0, 0, 1, 1, D3);
    chk("R7 en low blocks write", a_mb1_full_n, 1);
    b_op(0, 1, 1, 1, D3);
    chk("R7 b_rd high is not a write", b_mb2_full_n, 1);

    // R10: FIFO strobes
    @(negedge clk_a);
    a_cs_n = 0; a_en = 1; a_wr = 1; a_mbox = 0;
    #1 chk("R10 a_fifo_wr", a_fifo_wr, 1);
    a_wr = 0;
    #1 chk("R10 a_fifo_wr idle on read", a_fifo_wr, 0);
    a_cs_n = 1; a_en = 0;
    @(negedge clk_b);
    b_cs_n = 0; b_en = 1; b_rd = 1; b_mbox = 0;
    #1 chk("R10 b_fifo_rd", b_fifo_rd, 1);
    b_mbox = 1; b_en = 0;
    #1 chk("R10 b_fifo_rd idle on mailbox", b_fifo_rd, 0);
    b_cs_n = 1;
    wait_a(2);
    chk("R10 mailbox 1 not posted by FIFO write", a_mb1_full_n, 1);

    // R11: reset mid-flight
    a_op(0, 1, 1, 1, D3);
    wait_b(6);
    chk("R11 pre-reset b_mb1_full_n", b_mb1_full_n, 0);
    @(negedge clk_b);
    rst_a = 1'b1; rst_b = 1'b1;
    wait_b(4);
    rst_a = 1'b0; rst_b = 1'b0;
    b_mbox = 1'b1; b_cs_n = 1'b1;
    wait_b(2);
    chk("R11 b_mb1_full_n after reset", b_mb1_full_n, 1);
    chk("R11 a_mb1_full_n after reset", a_mb1_full_n, 1);
    chk("R11 mailbox 1 cleared", b_dout, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      ncmp++;
      nmis++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
      $finish;
    end
  end
endmodule